// File: doc/BRIEF.md
# Transport Stream PID Bitmap Filter

This block sits in a transport stream path and removes whole 188-byte packets based on their 13-bit packet identifier (PID). Each filter lane has its own bitmap of 1024 bytes, one bit for every possible PID. A bit set to 1 removes packets that carry that PID, and a bit at 0 lets them through. The lowest 32 PIDs carry the stream's own tables, so they always pass, whatever the bitmap holds for them.

Each lane takes a byte stream with a valid strobe and a packet-start flag. It stores the whole packet in a two-slot buffer while it looks up the PID's bit. It then replays a kept packet in the same stream format. A packet that lacks the sync byte 0x47 is thrown away, and the lane waits for the next start flag. Software reaches every bitmap through three host registers: a low index byte, a high index and filter select, and a data window. The data window lets software set or clear single bits by read-modify-write. A host access to a lane's bitmap takes that memory's single port for the cycle, and the lane's lookup waits for the next free cycle.

Top module: `pidf_top`

## Requirements
- R1: The PID is formed from bits 4:0 of packet byte 1 followed by byte 2. Its bitmap byte index is PID[12:3] and its bit within that byte is PID[2:0]. Host offset 0x8 holds index bits 7:0. Offset 0x9 holds index bits 9:8 in its bits 1:0 and the filter select in its bit 2. Both registers read back what was written.
- R2: If the bitmap bit is 1, the packet is removed. If it is 0, all 188 bytes are forwarded unchanged and in order. The first forwarded byte is flagged as packet start, and valid stays high across the whole packet.
- R3: Packets with PID 0x0000 to 0x001F are always forwarded, whatever bitmap bytes 0 to 3 contain. Those bytes still store and return host data.
- R4: A host write to offset 0xA stores the byte at the selected filter and index. A host read strobe at any offset presents the value on the read data port in the cycle after the strobe. A single-bit read-modify-write leaves the other seven bits unchanged.
- R5: Each lane decides only from its own filter's bitmap.
- R6: A packet whose first byte is not 0x47 is removed. Later bytes are ignored until the next packet-start flag.
- R7: A packet-start flag that arrives before a packet is complete abandons the partial packet. The new packet is captured from its first byte.
- R8: A host access to a filter's bitmap has priority over that lane's lookup. The lookup retries on the next free cycle, and the forward or remove decision is unaffected.
- R9: After reset, the output valid and start flags are low and the host read data is 0. A kept packet's first byte is registered on the clock edge after the edge that accepts its last input byte. Back-to-back input packets leave back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register offset (0x8, 0x9, 0xA) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after a read strobe |
| ts_in_valid | input | NUM_FILT | Per-lane input byte valid |
| ts_in_sop | input | NUM_FILT | Per-lane packet start flag |
| ts_in_data | input | 8*NUM_FILT | Per-lane input bytes, lane f at bits 8f+7:8f |
| ts_out_valid | output | NUM_FILT | Per-lane output byte valid |
| ts_out_sop | output | NUM_FILT | Per-lane output packet start |
| ts_out_data | output | 8*NUM_FILT | Per-lane output bytes |

## Verification
The lookup is driven with PIDs that fall in different bitmap bytes and bit positions, including the top index 1023 bit 7. Two PIDs share one byte, which shows that a read-modify-write touches only its own bit. PIDs in the forced range are sent against bitmap bytes filled with ones, and PID 0x0020 is sent as well, so the forced range is shown to end exactly at byte 4. The same PID is sent to both lanes with opposite bitmap settings to show that each lane uses its own bitmap. Bad sync bytes, truncated packets, back-to-back packets and a burst of host reads during a lookup cover the resync, abandon and priority paths.

// File: rtl/pidf_pkg.sv
package pidf_pkg;
   typedef logic [7:0] byte_t;
   localparam int unsigned PID_W     = 13;
   localparam byte_t       SYNC_BYTE = 8'h47;
   localparam logic [3:0]  REG_IDX_LO = 4'h8;
   localparam logic [3:0]  REG_IDX_HI = 4'h9;
   localparam logic [3:0]  REG_DATA   = 4'hA;
endpackage

// File: rtl/pidf_bank.sv
// Single-port bitmap store of one filter; host access wins over the lane lookup.
module pidf_bank
   import pidf_pkg::*;
#(
   parameter int unsigned IDX_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             h_req,
   input  logic             h_we,
   input  logic [IDX_W-1:0] h_idx,
   input  byte_t            h_wdata,
   input  logic             l_req,
   input  logic [IDX_W-1:0] l_idx,
   output logic             l_gnt,
   output byte_t            rd_data
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   byte_t            mem [DEPTH];
   logic [IDX_W-1:0] port_idx;
   logic             port_rd;

   assign l_gnt    = l_req & ~h_req;
   assign port_idx = h_req ? h_idx : l_idx;
   assign port_rd  = (h_req & ~h_we) | l_gnt;

   always_ff @(posedge clk) begin
      if (h_req && h_we) mem[port_idx] <= h_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data <= '0;
      else if (port_rd) rd_data <= mem[port_idx];
   end
endmodule

// File: rtl/pidf_lane.sv
// One filter lane: capture into a two-slot buffer, look up the PID bit, replay kept packets.
module pidf_lane
   import pidf_pkg::*;
#(
   parameter int unsigned PKT_LEN   = 188,
   parameter int unsigned IDX_W     = 10,
   parameter int unsigned LOW_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  byte_t            in_data,
   output logic             lk_req,
   output logic [IDX_W-1:0] lk_idx,
   input  logic             lk_gnt,
   input  byte_t            lk_data,
   output logic             out_valid,
   output logic             out_sop,
   output byte_t            out_data
);
   localparam int unsigned CNT_W  = $clog2(PKT_LEN);
   localparam int unsigned BUF_AW = $clog2(2 * PKT_LEN);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_LEN - 1);

   byte_t            pbuf [2 * PKT_LEN];
   logic             cap_on, wbank, rbank, send_on;
   logic [CNT_W-1:0] wcnt, rcnt, wslot;
   logic [4:0]       pid_hi_q;
   logic [PID_W-1:0] pid_q;
   logic             lk_pend, lk_wait, dec_valid, dec_drop;
   logic             low_pid, bit_drop, dec_now, drop_now, wr_en;
   logic [BUF_AW-1:0] waddr, raddr;

   assign lk_req = lk_pend;
   assign lk_idx = pid_q[PID_W-1:3];

   generate
      if (LOW_BYTES > 0) begin : g_low_force
         assign low_pid = (lk_idx < IDX_W'(LOW_BYTES));
      end else begin : g_no_force
         assign low_pid = 1'b0;
      end
   endgenerate

   assign bit_drop = lk_data[pid_q[2:0]] & ~low_pid;
   assign dec_now  = dec_valid | lk_wait;
   assign drop_now = dec_valid ? dec_drop : bit_drop;

   assign wr_en = in_valid & (in_sop ? (in_data == SYNC_BYTE) : cap_on);
   assign wslot = in_sop ? '0 : wcnt;
   assign waddr = BUF_AW'(wslot) + (wbank ? BUF_AW'(PKT_LEN) : BUF_AW'(0));
   assign raddr = BUF_AW'(rcnt)  + (rbank ? BUF_AW'(PKT_LEN) : BUF_AW'(0));

   always_ff @(posedge clk) begin
      if (wr_en) pbuf[waddr] <= in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_on    <= 1'b0;
         wbank     <= 1'b0;
         rbank     <= 1'b0;
         send_on   <= 1'b0;
         wcnt      <= '0;
         rcnt      <= '0;
         pid_hi_q  <= '0;
         pid_q     <= '0;
         lk_pend   <= 1'b0;
         lk_wait   <= 1'b0;
         dec_valid <= 1'b0;
         dec_drop  <= 1'b0;
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
         out_data  <= '0;
      end else begin
         // lookup: grant, then data one cycle later
         if (lk_gnt) begin
            lk_pend <= 1'b0;
            lk_wait <= 1'b1;
         end
         if (lk_wait) begin
            lk_wait   <= 1'b0;
            dec_valid <= 1'b1;
            dec_drop  <= bit_drop;
         end
         // replay
         if (send_on) begin
            out_valid <= 1'b1;
            out_sop   <= (rcnt == '0);
            out_data  <= pbuf[raddr];
            rcnt      <= rcnt + 1'b1;
            if (rcnt == LAST) send_on <= 1'b0;
         end else begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
         end
         // capture (placed last so a new start overrides older lookup state)
         if (in_valid) begin
            if (in_sop) begin
               cap_on    <= (in_data == SYNC_BYTE);
               wcnt      <= CNT_W'(1);
               lk_pend   <= 1'b0;
               lk_wait   <= 1'b0;
               dec_valid <= 1'b0;
            end else if (cap_on) begin
               if (wcnt == CNT_W'(1)) pid_hi_q <= in_data[4:0];
               if (wcnt == CNT_W'(2)) begin
                  pid_q   <= {pid_hi_q, in_data};
                  lk_pend <= 1'b1;
               end
               if (wcnt == LAST) begin
                  cap_on <= 1'b0;
                  wbank  <= ~wbank;
                  if (dec_now && !drop_now) begin
                     send_on <= 1'b1;
                     rbank   <= wbank;
                     rcnt    <= '0;
                  end
               end else begin
                  wcnt <= wcnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/pidf_top.sv
module pidf_top
   import pidf_pkg::*;
#(
   parameter int unsigned NUM_FILT  = 2,
   parameter int unsigned PKT_LEN   = 188,
   parameter int unsigned LOW_BYTES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_en,
   input  logic                  host_we,
   input  logic [3:0]            host_addr,
   input  logic [7:0]            host_wdata,
   output logic [7:0]            host_rdata,
   input  logic [NUM_FILT-1:0]   ts_in_valid,
   input  logic [NUM_FILT-1:0]   ts_in_sop,
   input  logic [NUM_FILT*8-1:0] ts_in_data,
   output logic [NUM_FILT-1:0]   ts_out_valid,
   output logic [NUM_FILT-1:0]   ts_out_sop,
   output logic [NUM_FILT*8-1:0] ts_out_data
);
   localparam int unsigned IDX_W  = PID_W - 3;
   localparam int unsigned HI_W   = IDX_W - 8;
   localparam int unsigned FSEL_W = $clog2(NUM_FILT);

   generate
      if (NUM_FILT < 2 || (NUM_FILT & (NUM_FILT - 1)) != 0) begin : g_bad_nf
         $error("NUM_FILT must be a power of two of at least 2");
      end
      if (PKT_LEN < 4) begin : g_bad_len
         $error("PKT_LEN too short to hold a PID");
      end
      if (HI_W + FSEL_W > 8) begin : g_bad_hi
         $error("high index and filter select do not fit one register");
      end
      if (LOW_BYTES > (1 << IDX_W)) begin : g_bad_low
         $error("LOW_BYTES exceeds bitmap depth");
      end
   endgenerate

   byte_t             idx_lo_q;
   logic [HI_W-1:0]   idx_hi_q;
   logic [FSEL_W-1:0] fsel_q, rd_fsel_q;
   logic              rd_bmp_q;
   byte_t             reg_rd_q, reg_val;
   logic              bmp_acc;
   logic [IDX_W-1:0]  host_idx;
   byte_t             bank_rd [NUM_FILT];

   assign bmp_acc  = host_en & (host_addr == REG_DATA);
   assign host_idx = {idx_hi_q, idx_lo_q};

   always_comb begin
      case (host_addr)
         REG_IDX_LO: reg_val = idx_lo_q;
         REG_IDX_HI: reg_val = 8'({fsel_q, idx_hi_q});
         default:    reg_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_lo_q  <= '0;
         idx_hi_q  <= '0;
         fsel_q    <= '0;
         rd_fsel_q <= '0;
         rd_bmp_q  <= 1'b0;
         reg_rd_q  <= '0;
      end else if (host_en) begin
         if (host_we) begin
            if (host_addr == REG_IDX_LO) idx_lo_q <= host_wdata;
            if (host_addr == REG_IDX_HI) begin
               idx_hi_q <= host_wdata[HI_W-1:0];
               fsel_q   <= host_wdata[HI_W +: FSEL_W];
            end
         end else begin
            rd_bmp_q  <= (host_addr == REG_DATA);
            rd_fsel_q <= fsel_q;
            reg_rd_q  <= reg_val;
         end
      end
   end

   assign host_rdata = rd_bmp_q ? bank_rd[rd_fsel_q] : reg_rd_q;

   for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
      logic             lreq, lgnt;
      logic [IDX_W-1:0] lidx;

      pidf_bank #(.IDX_W(IDX_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .h_req   (bmp_acc & (fsel_q == FSEL_W'(f))),
         .h_we    (host_we),
         .h_idx   (host_idx),
         .h_wdata (host_wdata),
         .l_req   (lreq),
         .l_idx   (lidx),
         .l_gnt   (lgnt),
         .rd_data (bank_rd[f])
      );

      pidf_lane #(.PKT_LEN(PKT_LEN), .IDX_W(IDX_W), .LOW_BYTES(LOW_BYTES)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (ts_in_valid[f]),
         .in_sop    (ts_in_sop[f]),
         .in_data   (ts_in_data[f*8 +: 8]),
         .lk_req    (lreq),
         .lk_idx    (lidx),
         .lk_gnt    (lgnt),
         .lk_data   (bank_rd[f]),
         .out_valid (ts_out_valid[f]),
         .out_sop   (ts_out_sop[f]),
         .out_data  (ts_out_data[f*8 +: 8])
      );
   end
endmodule

// File: rtl/pidf_chk.sv
module pidf_chk
   import pidf_pkg::*;
#(
   parameter int unsigned NUM_FILT = 2,
   parameter int unsigned PKT_LEN  = 188
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  host_en,
   input logic                  host_we,
   input logic [3:0]            host_addr,
   input logic [7:0]            host_wdata,
   input logic [7:0]            host_rdata,
   input logic [NUM_FILT-1:0]   ts_out_valid,
   input logic [NUM_FILT-1:0]   ts_out_sop,
   input logic [NUM_FILT*8-1:0] ts_out_data
);
   localparam int unsigned OC_W = $clog2(PKT_LEN + 1);

   logic [1:0] up_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              up_q <= '0;
      else if (up_q != 2'd3)   up_q <= up_q + 1'b1;
   end

   // R4: a data-window write followed at once by a read returns the written byte
   assert_data_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q == 2'd3 && host_en && !host_we && host_addr == REG_DATA &&
       $past(host_en && host_we && host_addr == REG_DATA))
      |=> host_rdata == $past(host_wdata, 2));

   // R1: low index register reads back its last write
   assert_idx_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q == 2'd3 && host_en && !host_we && host_addr == REG_IDX_LO &&
       $past(host_en && host_we && host_addr == REG_IDX_LO))
      |=> host_rdata == $past(host_wdata, 2));

   for (genvar f = 0; f < NUM_FILT; f++) begin : g_lane
      logic [OC_W-1:0] ocnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                ocnt_q <= '0;
         else if (ts_out_valid[f])  ocnt_q <= ts_out_sop[f] ? OC_W'(1) : ocnt_q + 1'b1;
      end

      assert_sop_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ts_out_sop[f] |-> ts_out_valid[f]);

      assert_sop_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ts_out_sop[f] |-> (ocnt_q == '0 || ocnt_q == OC_W'(PKT_LEN)));

      assert_no_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (ts_out_valid[f] && !ts_out_sop[f]) |->
         (ocnt_q != '0 && ocnt_q < OC_W'(PKT_LEN)));

      assert_idle_whole_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !ts_out_valid[f] |-> (ocnt_q == '0 || ocnt_q == OC_W'(PKT_LEN)));

      assert_head_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
         ts_out_sop[f] |-> ts_out_data[f*8 +: 8] == SYNC_BYTE);
   end
endmodule

bind pidf_top pidf_chk #(.NUM_FILT(NUM_FILT), .PKT_LEN(PKT_LEN)) u_chk (.*);

// File: tb/sim_pidf_top.sv
`timescale 1ns/1ps
module sim_pidf_top;
   localparam int NF = 2;
   localparam int PL = 188;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic            host_en = 0, host_we = 0;
   logic [3:0]      host_addr = '0;
   logic [7:0]      host_wdata = '0, host_rdata;
   logic [NF-1:0]   ts_in_valid = '0, ts_in_sop = '0;
   logic [NF*8-1:0] ts_in_data = '0;
   logic [NF-1:0]   ts_out_valid, ts_out_sop;
   logic [NF*8-1:0] ts_out_data;

   pidf_top #(.NUM_FILT(NF), .PKT_LEN(PL), .LOW_BYTES(4)) u0 (
      .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ts_in_valid(ts_in_valid), .ts_in_sop(ts_in_sop), .ts_in_data(ts_in_data),
      .ts_out_valid(ts_out_valid), .ts_out_sop(ts_out_sop), .ts_out_data(ts_out_data));

   int n_chk = 0, n_err = 0, cyc = 0, last_in_cyc = 0;
   logic [7:0] exp_pkt [NF][PL];
   int rx_idx [NF], rx_pkts [NF], rx_bad [NF], rx_first [NF];

   always @(posedge clk) cyc <= cyc + 1;

   // vector fields: {lane, bit value, expect forwarded, pid[12:0]}
   localparam logic [15:0] VEC [6] = '{
      {1'b0, 1'b0, 1'b1, 13'h0100},
      {1'b0, 1'b1, 1'b0, 13'h0101},
      {1'b1, 1'b0, 1'b1, 13'h1FFF},
      {1'b1, 1'b1, 1'b0, 13'h0020},
      {1'b0, 1'b0, 1'b1, 13'h0407},
      {1'b1, 1'b1, 1'b0, 13'h0A3C}
   };

   initial begin
      for (int f = 0; f < NF; f++) begin
         rx_idx[f] = PL; rx_pkts[f] = 0; rx_bad[f] = 0; rx_first[f] = 0;
      end
   end

   always @(negedge clk) begin
      for (int f = 0; f < NF; f++) begin
         if (ts_out_valid[f]) begin
            if (ts_out_sop[f]) begin
               rx_idx[f] = 0;
               rx_first[f] = cyc;
            end
            if (rx_idx[f] >= PL) rx_bad[f]++;
            else begin
               if (ts_out_data[f*8 +: 8] != exp_pkt[f][rx_idx[f]]) rx_bad[f]++;
               rx_idx[f]++;
               if (rx_idx[f] == PL) rx_pkts[f]++;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pkt_byte(input logic [12:0] pid, input int k, input int seed);
      if (k == 0)      return 8'h47;
      else if (k == 1) return {3'b000, pid[12:8]};
      else if (k == 2) return pid[7:0];
      else             return 8'(k * 3 + seed);
   endfunction

   task automatic hwr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); host_en = 1; host_we = 1; host_addr = a; host_wdata = d;
      @(negedge clk); host_en = 0; host_we = 0;
   endtask

   task automatic hrd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); host_en = 1; host_we = 0; host_addr = a;
      @(negedge clk); host_en = 0; d = host_rdata;
   endtask

   task automatic point(input int lane, input int idx);
      hwr(4'h8, 8'(idx));
      hwr(4'h9, {5'b00000, 1'(lane), 2'(idx >> 8)});
   endtask

   task automatic setbit(input int lane, input logic [12:0] pid, input bit v);
      logic [7:0] b;
      point(lane, int'(pid[12:3]));
      hrd(4'hA, b);
      b[pid[2:0]] = v;
      hwr(4'hA, b);
   endtask

   task automatic send_pkt(input int lane, input logic [12:0] pid, input logic [7:0] sync,
                           input int seed, input int nbytes);
      for (int k = 0; k < nbytes; k++) begin
         logic [7:0] b;
         b = (k == 0) ? sync : pkt_byte(pid, k, seed);
         exp_pkt[lane][k] = pkt_byte(pid, k, seed);
         @(negedge clk);
         ts_in_valid[lane] = 1'b1;
         ts_in_sop[lane] = (k == 0);
         ts_in_data[lane*8 +: 8] = b;
         last_in_cyc = cyc;
      end
   endtask

   task automatic stop_in(input int lane);
      @(negedge clk);
      ts_in_valid[lane] = 1'b0;
      ts_in_sop[lane] = 1'b0;
   endtask

   task automatic xfer(input int lane, input logic [12:0] pid, input int seed,
                       output int got, output int bad);
      int p0, b0;
      p0 = rx_pkts[lane]; b0 = rx_bad[lane];
      send_pkt(lane, pid, 8'h47, seed, PL);
      stop_in(lane);
      repeat (200) @(negedge clk);
      got = rx_pkts[lane] - p0;
      bad = rx_bad[lane] - b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int got, bad, p0, b0;
      logic [7:0] rv;

      repeat (3) @(negedge clk);
      check(ts_out_valid == '0 && ts_out_sop == '0, "R9 reset outputs", int'(ts_out_valid), 0);
      check(host_rdata == 8'h00, "R9 reset rdata", int'(host_rdata), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: index registers read back
      hwr(4'h8, 8'h5A); hrd(4'h8, rv);
      check(rv == 8'h5A, "R1 index low readback", int'(rv), 'h5A);
      hwr(4'h9, 8'h07); hrd(4'h9, rv);
      check(rv == 8'h07, "R1 index high/select readback", int'(rv), 7);

      // block everything in both filters (all bytes 0xFF)
      for (int f = 0; f < NF; f++)
         for (int i = 0; i < 1024; i++) begin
            point(f, i);
            hwr(4'hA, 8'hFF);
         end

      // table walk: R1 bit placement, R2 forward/remove
      for (int v = 0; v < 6; v++) begin
         int lane;
         lane = int'(VEC[v][15]);
         setbit(lane, VEC[v][12:0], VEC[v][14]);
         xfer(lane, VEC[v][12:0], v, got, bad);
         check(got == int'(VEC[v][13]), "R1 R2 vector decision", got, int'(VEC[v][13]));
         check(bad == 0, "R2 vector byte content", bad, 0);
      end

      // R4: read-modify-write kept neighbouring bit
      point(0, 'h20); hrd(4'hA, rv);
      check(rv == 8'hFE, "R4 rmw byte value", int'(rv), 'hFE);
      xfer(0, 13'h0100, 9, got, bad);
      check(got == 1 && bad == 0, "R4 rmw kept pass bit", got, 1);

      // R3: forced low range
      xfer(0, 13'h0005, 11, got, bad);
      check(got == 1 && bad == 0, "R3 low pid 0x0005", got, 1);
      xfer(1, 13'h001F, 12, got, bad);
      check(got == 1 && bad == 0, "R3 low pid 0x001F", got, 1);
      xfer(0, 13'h0020, 13, got, bad);
      check(got == 0, "R3 pid 0x0020 not forced", got, 0);
      point(0, 3); hrd(4'hA, rv);
      check(rv == 8'hFF, "R3 low byte stores host data", int'(rv), 'hFF);

      // R5: lanes use their own bitmaps
      xfer(1, 13'h0407, 14, got, bad);
      check(got == 0, "R5 lane1 ignores filter0 bit", got, 0);
      xfer(0, 13'h1FFF, 15, got, bad);
      check(got == 0, "R5 lane0 ignores filter1 bit", got, 0);

      // R6: bad sync then good packet
      p0 = rx_pkts[0];
      send_pkt(0, 13'h0100, 8'h48, 16, PL);
      stop_in(0);
      repeat (200) @(negedge clk);
      check(rx_pkts[0] - p0 == 0, "R6 bad sync removed", rx_pkts[0] - p0, 0);
      xfer(0, 13'h0100, 17, got, bad);
      check(got == 1 && bad == 0, "R6 resync on next start", got, 1);

      // R7: truncated packet abandoned
      p0 = rx_pkts[0]; b0 = rx_bad[0];
      send_pkt(0, 13'h0100, 8'h47, 40, 60);
      send_pkt(0, 13'h0100, 8'h47, 18, PL);
      stop_in(0);
      repeat (200) @(negedge clk);
      check(rx_pkts[0] - p0 == 1, "R7 partial abandoned", rx_pkts[0] - p0, 1);
      check(rx_bad[0] - b0 == 0, "R7 full packet intact", rx_bad[0] - b0, 0);

      // R8: host reads hog filter 0 during the lookup
      point(0, 0);
      p0 = rx_pkts[0]; b0 = rx_bad[0];
      fork
         send_pkt(0, 13'h0100, 8'h47, 19, PL);
         begin
            @(negedge clk); host_en = 1; host_we = 0; host_addr = 4'hA;
            repeat (40) @(negedge clk);
            host_en = 0;
         end
      join
      stop_in(0);
      repeat (200) @(negedge clk);
      check(rx_pkts[0] - p0 == 1 && rx_bad[0] - b0 == 0, "R8 pass under host load", rx_pkts[0] - p0, 1);
      p0 = rx_pkts[0];
      fork
         send_pkt(0, 13'h0101, 8'h47, 20, PL);
         begin
            @(negedge clk); host_en = 1; host_we = 0; host_addr = 4'hA;
            repeat (40) @(negedge clk);
            host_en = 0;
         end
      join
      stop_in(0);
      repeat (200) @(negedge clk);
      check(rx_pkts[0] - p0 == 0, "R8 drop under host load", rx_pkts[0] - p0, 0);

      // R9: latency and back-to-back
      xfer(1, 13'h1FFF, 21, got, bad);
      check(rx_first[1] - last_in_cyc == 2, "R9 first byte latency", rx_first[1] - last_in_cyc, 2);
      p0 = rx_pkts[1]; b0 = rx_bad[1];
      send_pkt(1, 13'h1FFF, 8'h47, 22, PL);
      send_pkt(1, 13'h1FFF, 8'h47, 22, PL);
      stop_in(1);
      repeat (200) @(negedge clk);
      check(rx_pkts[1] - p0 == 2, "R9 back-to-back count", rx_pkts[1] - p0, 2);
      check(rx_bad[1] - b0 == 0, "R9 back-to-back content", rx_bad[1] - b0, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule